// File: doc/BRIEF.md
# Sequential Prefetch Stream Buffer

This block sits next to a direct-mapped instruction cache and keeps a handful of memory blocks fetched ahead of demand. When the cache misses, it presents the block address here. If the block is held in the buffer, it comes back one cycle later without any trip to memory. If it is not held, the block is fetched from the lower-level memory and returned for the cache refill. In both cases the block that follows the missed one in address order is then fetched into the buffer, so a stream of sequential misses is mostly served at buffer speed.

The buffer is a small fully associative store that compares every tag in parallel. New prefetched blocks replace the entry that was written longest ago. Only one memory transaction is open at a time. A demand fetch always goes out before a prefetch that has not yet been issued. A lookup for a block whose prefetch is already on its way waits for that response instead of asking memory a second time. A flush input, raised after a change of control flow, discards everything the buffer holds. Separate instances can serve the instruction and the data side.

Top module: `stream_prefetch_buf`

## Requirements
- R1: After reset, miss_ready is 1, fill_valid is 0, mem_req_valid is 0 and no block is held.
- R2: An accepted miss whose block is neither held nor being prefetched issues a demand request (mem_req_pf = 0) for that block. The fill then carries the memory data unchanged, with fill_src_buf = 0.
- R3: Every accepted miss is followed by a prefetch request (mem_req_pf = 1) for block + 1, modulo 2^ADDR_W. It is issued only once the demand has been served, and its response is stored in the buffer.
- R4: A miss whose block is held gives fill_valid in the cycle after acceptance, with fill_src_buf = 1 and the held data. No memory request is made for that block.
- R5: A block served from the buffer leaves it. A later miss to the same block goes to memory.
- R6: A miss on a block whose prefetch is outstanding issues no new request. It is filled from that prefetch response, with fill_src_buf = 0.
- R7: The buffer holds ENTRIES blocks. A stored prefetch overwrites the entry written longest ago.
- R8: A cycle with flush high invalidates every entry and cancels an unissued prefetch. It also drops the data of an outstanding prefetch unless a lookup is waiting for it. miss_ready is low while flush is high.
- R9: At most one memory request is outstanding. No request is made between an accepted request and its response.
- R10: A demand request goes out before any unissued prefetch. A newly accepted miss replaces the unissued prefetch with its own block + 1.
- R11: Apart from a buffer hit, miss_ready is low from the cycle after acceptance until the fill. Each accepted miss gives exactly one fill.
- R12: No prefetch is issued for block + 1 when that block is already held or already being prefetched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all held and pending prefetches |
| miss_valid | input | 1 | Cache miss lookup request |
| miss_blk | input | ADDR_W | Block address of the miss |
| miss_ready | output | 1 | A miss can be accepted this cycle |
| fill_valid | output | 1 | Refill block valid (one-cycle pulse) |
| fill_blk | output | ADDR_W | Block address of the refill |
| fill_data | output | WORD_W*WORDS | Refill block, word i at bits [i*WORD_W +: WORD_W] |
| fill_src_buf | output | 1 | 1 when the refill came from a held entry |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_blk | output | ADDR_W | Block address requested |
| mem_req_pf | output | 1 | 1 for a prefetch, 0 for a demand fetch |
| mem_rsp_valid | input | 1 | Memory read response valid |
| mem_rsp_data | input | WORD_W*WORDS | Memory read response block |

## Verification
The hardest case to reach is demand priority. It needs a prefetch that is pending but unissued at the moment a new miss arrives, and at the ports that moment lasts only the cycle between a hit and the prefetch going out. The stimulus holds mem_req_ready low across a buffer hit, so the prefetch it creates stays queued, and then presents a miss on a block that is not held. Once memory becomes ready again, the request log must show the new demand first and the new block + 1 prefetch second, with the older prefetch gone. Two more sequences cover lookups that collide with an outstanding prefetch and five back-to-back prefetches into four entries.

// File: rtl/spb_pkg.sv
package spb_pkg;

    localparam int SPB_ADDR_W  = 28;
    localparam int SPB_WORD_W  = 32;
    localparam int SPB_WORDS   = 4;
    localparam int SPB_ENTRIES = 4;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_DEM_REQ  = 2'd1,
        ST_DEM_WAIT = 2'd2,
        ST_PF_WAIT  = 2'd3
    } ctrl_state_e;

    typedef enum logic {
        SRC_MEMORY = 1'b0,
        SRC_BUFFER = 1'b1
    } fill_src_e;

endpackage

// File: rtl/spb_store.sv
module spb_store
    import spb_pkg::*;
#(
    parameter int ENTRIES = SPB_ENTRIES,
    parameter int ADDR_W  = SPB_ADDR_W,
    parameter int DATA_W  = SPB_WORD_W * SPB_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [ADDR_W-1:0] lk_blk,
    input  logic [ADDR_W-1:0] nx_blk,
    input  logic              consume,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_blk,
    input  logic [DATA_W-1:0] wr_data,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    output logic              nx_hit
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] tag;
        logic [DATA_W-1:0] data;
    } entry_t;

    entry_t             ent_q [ENTRIES];
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] nx_match;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   wptr_q;
    logic [IDX_W-1:0]   wptr_nxt;

    // Parallel tag compare, one comparator pair per entry
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g] = ent_q[g].valid && (ent_q[g].tag == lk_blk);
        assign nx_match[g] = ent_q[g].valid && (ent_q[g].tag == nx_blk);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign lk_hit   = |lk_match;
    assign nx_hit   = |nx_match;
    assign lk_data  = ent_q[hit_idx].data;
    assign wptr_nxt = (wptr_q == IDX_W'(ENTRIES - 1)) ? '0 : wptr_q + IDX_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i].valid <= 1'b0;
            wptr_q <= '0;
        end else if (flush) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i].valid <= 1'b0;
        end else begin
            if (consume && lk_hit) ent_q[hit_idx].valid <= 1'b0;
            if (wr_en) begin
                ent_q[wptr_q] <= '{valid: 1'b1, tag: wr_blk, data: wr_data};
                wptr_q        <= wptr_nxt;
            end
        end
    end

endmodule

// File: rtl/spb_memport.sv
module spb_memport
    import spb_pkg::*;
#(
    parameter int ADDR_W = SPB_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              dem_want,
    input  logic [ADDR_W-1:0] dem_blk,
    input  logic              pf_want,
    input  logic [ADDR_W-1:0] pf_blk,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_blk,
    output logic              mem_req_pf,
    input  logic              mem_rsp_valid,
    output logic              issued_dem,
    output logic              issued_pf,
    output logic              out_busy,
    output logic              out_is_pf,
    output logic [ADDR_W-1:0] out_blk,
    output logic              out_drop,
    output logic              rsp_fire
);

    logic fire;

    // Demand wins over prefetch; nothing goes out while a transaction is open
    assign mem_req_valid = !out_busy && (dem_want || pf_want);
    assign mem_req_pf    = !dem_want;
    assign mem_req_blk   = dem_want ? dem_blk : pf_blk;
    assign fire          = mem_req_valid && mem_req_ready;
    assign issued_dem    = fire && !mem_req_pf;
    assign issued_pf     = fire && mem_req_pf;
    assign rsp_fire      = mem_rsp_valid && out_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_busy  <= 1'b0;
            out_is_pf <= 1'b0;
            out_blk   <= '0;
            out_drop  <= 1'b0;
        end else begin
            if (rsp_fire) begin
                out_busy <= 1'b0;
            end else if (fire) begin
                out_busy  <= 1'b1;
                out_is_pf <= mem_req_pf;
                out_blk   <= mem_req_blk;
                out_drop  <= 1'b0;
            end
            if (flush && out_busy && out_is_pf) out_drop <= 1'b1;
        end
    end

endmodule

// File: rtl/spb_ctrl.sv
module spb_ctrl
    import spb_pkg::*;
#(
    parameter int ADDR_W = SPB_ADDR_W,
    parameter int DATA_W = SPB_WORD_W * SPB_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_blk,
    output logic              miss_ready,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_blk,
    output logic [DATA_W-1:0] fill_data,
    output logic              fill_src_buf,
    output logic [ADDR_W-1:0] nx_blk,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_data,
    input  logic              nx_hit,
    output logic              consume,
    output logic              wr_en,
    input  logic              out_busy,
    input  logic              out_is_pf,
    input  logic [ADDR_W-1:0] out_blk,
    input  logic              out_drop,
    input  logic              rsp_fire,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              issued_dem,
    input  logic              issued_pf,
    output logic              dem_want,
    output logic [ADDR_W-1:0] dem_blk,
    output logic              pf_want,
    output logic [ADDR_W-1:0] pf_blk
);

    ctrl_state_e       state_q;
    fill_src_e         fill_src_q;
    logic              pf_pend_q;
    logic [ADDR_W-1:0] pf_blk_q;
    logic [ADDR_W-1:0] req_blk_q;
    logic              acc;
    logic              inflight_hit;
    logic              inflight_nx;
    logic              pf_need;
    logic              rsp_take;

    assign miss_ready   = (state_q == ST_IDLE) && !flush;
    assign acc          = miss_valid && miss_ready;
    assign nx_blk       = miss_blk + ADDR_W'(1);
    assign inflight_hit = out_busy && out_is_pf && (out_blk == miss_blk);
    assign inflight_nx  = out_busy && out_is_pf && (out_blk == nx_blk);
    assign pf_need      = !nx_hit && !inflight_nx;

    // A response is taken by the waiting lookup instead of being stored
    assign rsp_take = rsp_fire && ((state_q == ST_PF_WAIT) ||
                                   (acc && !lk_hit && inflight_hit));
    assign wr_en    = rsp_fire && out_is_pf && !out_drop && !rsp_take;
    assign consume  = acc && lk_hit;

    assign dem_want     = (state_q == ST_DEM_REQ);
    assign dem_blk      = req_blk_q;
    assign pf_want      = pf_pend_q && (state_q == ST_IDLE) && !acc;
    assign pf_blk       = pf_blk_q;
    assign fill_src_buf = (fill_src_q == SRC_BUFFER);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            pf_pend_q  <= 1'b0;
            pf_blk_q   <= '0;
            req_blk_q  <= '0;
            fill_valid <= 1'b0;
            fill_blk   <= '0;
            fill_data  <= '0;
            fill_src_q <= SRC_MEMORY;
        end else begin
            fill_valid <= 1'b0;
            if (issued_pf || flush) pf_pend_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (acc) begin
                        req_blk_q <= miss_blk;
                        pf_blk_q  <= nx_blk;
                        pf_pend_q <= pf_need;
                        if (lk_hit) begin
                            fill_valid <= 1'b1;
                            fill_blk   <= miss_blk;
                            fill_data  <= lk_data;
                            fill_src_q <= SRC_BUFFER;
                        end else if (inflight_hit) begin
                            if (rsp_fire) begin
                                fill_valid <= 1'b1;
                                fill_blk   <= miss_blk;
                                fill_data  <= rsp_data;
                                fill_src_q <= SRC_MEMORY;
                            end else begin
                                state_q <= ST_PF_WAIT;
                            end
                        end else begin
                            state_q <= ST_DEM_REQ;
                        end
                    end
                end
                ST_DEM_REQ: begin
                    if (issued_dem) state_q <= ST_DEM_WAIT;
                end
                ST_DEM_WAIT, ST_PF_WAIT: begin
                    if (rsp_fire) begin
                        fill_valid <= 1'b1;
                        fill_blk   <= req_blk_q;
                        fill_data  <= rsp_data;
                        fill_src_q <= SRC_MEMORY;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/stream_prefetch_buf.sv
module stream_prefetch_buf
    import spb_pkg::*;
#(
    parameter int ADDR_W  = SPB_ADDR_W,
    parameter int WORD_W  = SPB_WORD_W,
    parameter int WORDS   = SPB_WORDS,
    parameter int ENTRIES = SPB_ENTRIES
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      flush,
    input  logic                      miss_valid,
    input  logic [ADDR_W-1:0]         miss_blk,
    output logic                      miss_ready,
    output logic                      fill_valid,
    output logic [ADDR_W-1:0]         fill_blk,
    output logic [WORD_W*WORDS-1:0]   fill_data,
    output logic                      fill_src_buf,
    output logic                      mem_req_valid,
    input  logic                      mem_req_ready,
    output logic [ADDR_W-1:0]         mem_req_blk,
    output logic                      mem_req_pf,
    input  logic                      mem_rsp_valid,
    input  logic [WORD_W*WORDS-1:0]   mem_rsp_data
);

    localparam int DATA_W = WORD_W * WORDS;

    logic              lk_hit, nx_hit, consume, wr_en;
    logic [DATA_W-1:0] lk_data;
    logic [ADDR_W-1:0] nx_blk;
    logic              out_busy, out_is_pf, out_drop, rsp_fire;
    logic [ADDR_W-1:0] out_blk;
    logic              issued_dem, issued_pf, dem_want, pf_want;
    logic [ADDR_W-1:0] dem_blk, pf_blk;

    spb_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .lk_blk  (miss_blk),
        .nx_blk  (nx_blk),
        .consume (consume),
        .wr_en   (wr_en),
        .wr_blk  (out_blk),
        .wr_data (mem_rsp_data),
        .lk_hit  (lk_hit),
        .lk_data (lk_data),
        .nx_hit  (nx_hit)
    );

    spb_memport #(.ADDR_W(ADDR_W)) u_memport (
        .clk           (clk),
        .rst           (rst),
        .flush         (flush),
        .dem_want      (dem_want),
        .dem_blk       (dem_blk),
        .pf_want       (pf_want),
        .pf_blk        (pf_blk),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_blk   (mem_req_blk),
        .mem_req_pf    (mem_req_pf),
        .mem_rsp_valid (mem_rsp_valid),
        .issued_dem    (issued_dem),
        .issued_pf     (issued_pf),
        .out_busy      (out_busy),
        .out_is_pf     (out_is_pf),
        .out_blk       (out_blk),
        .out_drop      (out_drop),
        .rsp_fire      (rsp_fire)
    );

    spb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .flush        (flush),
        .miss_valid   (miss_valid),
        .miss_blk     (miss_blk),
        .miss_ready   (miss_ready),
        .fill_valid   (fill_valid),
        .fill_blk     (fill_blk),
        .fill_data    (fill_data),
        .fill_src_buf (fill_src_buf),
        .nx_blk       (nx_blk),
        .lk_hit       (lk_hit),
        .lk_data      (lk_data),
        .nx_hit       (nx_hit),
        .consume      (consume),
        .wr_en        (wr_en),
        .out_busy     (out_busy),
        .out_is_pf    (out_is_pf),
        .out_blk      (out_blk),
        .out_drop     (out_drop),
        .rsp_fire     (rsp_fire),
        .rsp_data     (mem_rsp_data),
        .issued_dem   (issued_dem),
        .issued_pf    (issued_pf),
        .dem_want     (dem_want),
        .dem_blk      (dem_blk),
        .pf_want      (pf_want),
        .pf_blk       (pf_blk)
    );

endmodule

// File: rtl/stream_prefetch_buf_chk.sv
module stream_prefetch_buf_chk (
    input logic clk,
    input logic rst,
    input logic flush,
    input logic miss_valid,
    input logic miss_ready,
    input logic fill_valid,
    input logic fill_src_buf,
    input logic mem_req_valid,
    input logic mem_req_ready,
    input logic mem_req_pf,
    input logic mem_rsp_valid
);

    logic pend_q;   // a miss has been accepted and not yet filled
    logic busy_q;   // a memory request has been accepted and not answered

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            if (miss_valid && miss_ready) pend_q <= 1'b1;
            else if (fill_valid)          pend_q <= 1'b0;
            if (mem_req_valid && mem_req_ready) busy_q <= 1'b1;
            else if (mem_rsp_valid)             busy_q <= 1'b0;
        end
    end

    p_single_out_r9: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !mem_req_valid);

    p_served_r11: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && miss_ready) |=> (fill_valid || !miss_ready));

    p_fill_owner_r11: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> pend_q);

    p_hit_time_r4: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && fill_src_buf) |-> $past(miss_valid && miss_ready));

    p_demand_first_r10: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !fill_valid && mem_req_valid) |-> !mem_req_pf);

    p_flush_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> !(fill_valid && fill_src_buf));

endmodule

bind stream_prefetch_buf stream_prefetch_buf_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .flush         (flush),
    .miss_valid    (miss_valid),
    .miss_ready    (miss_ready),
    .fill_valid    (fill_valid),
    .fill_src_buf  (fill_src_buf),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_pf    (mem_req_pf),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/sim_stream_prefetch_buf.sv
`timescale 1ns/1ps
module sim_stream_prefetch_buf;

    localparam int ADDR_W = 28;
    localparam int WORD_W = 32;
    localparam int WORDS  = 4;
    localparam int DATA_W = WORD_W * WORDS;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              flush = 1'b0;
    logic              miss_valid = 1'b0;
    logic [ADDR_W-1:0] miss_blk = '0;
    logic              miss_ready;
    logic              fill_valid;
    logic [ADDR_W-1:0] fill_blk;
    logic [DATA_W-1:0] fill_data;
    logic              fill_src_buf;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b1;
    logic [ADDR_W-1:0] mem_req_blk;
    logic              mem_req_pf;
    logic              mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0] mem_rsp_data = '0;

    always #10 clk = ~clk;

    stream_prefetch_buf #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .ENTRIES(4)) u0 (
        .clk(clk), .rst(rst), .flush(flush),
        .miss_valid(miss_valid), .miss_blk(miss_blk), .miss_ready(miss_ready),
        .fill_valid(fill_valid), .fill_blk(fill_blk), .fill_data(fill_data),
        .fill_src_buf(fill_src_buf),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_blk(mem_req_blk), .mem_req_pf(mem_req_pf),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    typedef struct {
        logic [ADDR_W-1:0] blk;
        logic              src;
    } exp_t;

    exp_t sb_q[$];
    int   errors = 0;
    int   checks = 0;

    // memory model state and request log
    logic [ADDR_W-1:0] log_blk [64];
    bit                log_pf  [64];
    int                req_cnt = 0;
    int                overlap = 0;
    int                lat     = 3;
    bit                mem_rdy = 1'b1;
    bit                m_busy  = 1'b0;
    int                m_cnt   = 0;
    logic [ADDR_W-1:0] m_blk   = '0;

    function automatic logic [DATA_W-1:0] mem_data(logic [ADDR_W-1:0] b);
        logic [DATA_W-1:0] d;
        for (int w = 0; w < WORDS; w++) d[w*WORD_W +: WORD_W] = {b[23:0], 8'(w)} ^ 32'h5A00_0000;
        return d;
    endfunction

    task automatic check(bit ok, string req, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory model: one transaction at a time, response lat+1 cycles after acceptance
    initial begin
        forever begin
            @(negedge clk); #1;
            if (mem_rsp_valid) mem_rsp_valid = 1'b0;
            if (m_busy) begin
                if (m_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_data(m_blk);
                    m_busy        = 1'b0;
                end else begin
                    m_cnt--;
                end
            end
            mem_req_ready = mem_rdy;
            if (!rst && mem_req_valid && mem_req_ready) begin
                if (m_busy || mem_rsp_valid) overlap++;
                if (req_cnt < 64) begin
                    log_blk[req_cnt] = mem_req_blk;
                    log_pf[req_cnt]  = mem_req_pf;
                end
                req_cnt++;
                m_busy = 1'b1;
                m_cnt  = lat;
                m_blk  = mem_req_blk;
            end
        end
    end

    // monitor: pops the scoreboard on every fill
    initial begin
        forever begin
            @(negedge clk); #1;
            if (!rst && fill_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R11", "fill with no accepted miss", DATA_W'(fill_blk), '0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(fill_blk == e.blk, e.src ? "R4" : "R2", "fill block",
                          DATA_W'(fill_blk), DATA_W'(e.blk));
                    check(fill_data == mem_data(e.blk), e.src ? "R4" : "R2", "fill data",
                          fill_data, mem_data(e.blk));
                    check(fill_src_buf == e.src, e.src ? "R4" : "R6", "fill source",
                          DATA_W'(fill_src_buf), DATA_W'(e.src));
                end
            end
        end
    end

    // driver: is_hit selects which cycle-after-accept check applies
    task automatic do_miss(logic [ADDR_W-1:0] b, bit is_hit);
        exp_t e;
        @(negedge clk);
        while (!miss_ready) @(negedge clk);
        e.blk = b;
        e.src = is_hit;
        sb_q.push_back(e);
        miss_valid = 1'b1;
        miss_blk   = b;
        @(posedge clk); #1;
        miss_valid = 1'b0;
        if (is_hit) check(fill_valid == 1'b1, "R4", "hit fill one cycle after accept",
                          DATA_W'(fill_valid), 1);
        else        check(miss_ready == 1'b0, "R11", "miss_ready low while served",
                          DATA_W'(miss_ready), 0);
    endtask

    task automatic wait_idle();
        do begin
            @(negedge clk); #2;
        end while (sb_q.size() != 0 || !miss_ready);
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_log(int idx, logic [ADDR_W-1:0] b, bit pf, string req);
        bit ok;
        ok = (idx < req_cnt) && (idx < 64) && (log_blk[idx] == b) && (log_pf[idx] == pf);
        check(ok, req, pf ? "prefetch request" : "demand request",
              (idx < 64) ? DATA_W'({log_pf[idx], log_blk[idx]}) : '0, DATA_W'({pf, b}));
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1'b1;
        #2;
        check(miss_ready == 1'b0, "R8", "miss_ready during flush", DATA_W'(miss_ready), 0);
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R11 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #2;
        check(miss_ready == 1'b1, "R1", "miss_ready after reset", DATA_W'(miss_ready), 1);
        check(fill_valid == 1'b0, "R1", "fill_valid after reset", DATA_W'(fill_valid), 0);
        check(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", DATA_W'(mem_req_valid), 0);

        // R2 and R3: cold miss, demand then sequential prefetch
        do_miss(28'h100, 1'b0);
        wait_idle();
        settle(12);
        check_log(0, 28'h100, 1'b0, "R2");
        check_log(1, 28'h101, 1'b1, "R3");
        check(req_cnt == 2, "R3", "request count", DATA_W'(req_cnt), 2);

        // R4: hit on the prefetched block, new prefetch follows
        do_miss(28'h101, 1'b1);
        settle(12);
        check(req_cnt == 3, "R4", "no demand for a held block", DATA_W'(req_cnt), 3);
        check_log(2, 28'h102, 1'b1, "R3");

        // R6: lookup on a block whose prefetch is outstanding
        lat = 8;
        n = req_cnt;
        do_miss(28'h200, 1'b0);
        wait_idle();
        do_miss(28'h201, 1'b0);
        wait_idle();
        settle(20);
        check(req_cnt == n + 3, "R6", "no duplicate request", DATA_W'(req_cnt), DATA_W'(n + 3));
        check_log(n,     28'h200, 1'b0, "R6");
        check_log(n + 1, 28'h201, 1'b1, "R6");
        check_log(n + 2, 28'h202, 1'b1, "R6");

        // R5 and R12: consume then miss again; next block already held
        lat = 3;
        n = req_cnt;
        do_miss(28'h202, 1'b1);
        settle(12);
        do_miss(28'h202, 1'b0);
        wait_idle();
        settle(12);
        check_log(n + 1, 28'h202, 1'b0, "R5");
        check(req_cnt == n + 2, "R12", "prefetch suppressed for held block", DATA_W'(req_cnt), DATA_W'(n + 2));

        // R8: flush discards held blocks
        pulse_flush();
        n = req_cnt;
        do_miss(28'h203, 1'b0);
        wait_idle();
        settle(12);
        check_log(n, 28'h203, 1'b0, "R8");

        // R7: five prefetches into four entries
        pulse_flush();
        for (int k = 3; k <= 7; k++) begin
            do_miss(ADDR_W'(k * 256), 1'b0);
            wait_idle();
            settle(10);
        end
        do_miss(28'h401, 1'b1);
        wait_idle();
        settle(10);
        n = req_cnt;
        do_miss(28'h301, 1'b0);
        wait_idle();
        settle(10);
        check_log(n, 28'h301, 1'b0, "R7");

        // R10: demand overtakes an unissued prefetch and replaces it
        pulse_flush();
        do_miss(28'h800, 1'b0);
        wait_idle();
        settle(10);
        mem_rdy = 1'b0;
        do_miss(28'h801, 1'b1);
        settle(3);
        n = req_cnt;
        do_miss(28'h900, 1'b0);
        settle(4);
        check(req_cnt == n, "R10", "nothing accepted while memory not ready", DATA_W'(req_cnt), DATA_W'(n));
        mem_rdy = 1'b1;
        wait_idle();
        settle(12);
        check_log(n,     28'h900, 1'b0, "R10");
        check_log(n + 1, 28'h901, 1'b1, "R10");
        check(req_cnt == n + 2, "R10", "stale prefetch dropped", DATA_W'(req_cnt), DATA_W'(n + 2));

        check(overlap == 0, "R9", "overlapping memory requests", DATA_W'(overlap), 0);
        check(sb_q.size() == 0, "R11", "missing fills", DATA_W'(sb_q.size()), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule